// File: doc/BRIEF.md
# Single-Bit Clock-Crossing Synchronizer with Built-In Usage Monitors

This block moves one level signal, produced under some clock unrelated to the receiving logic, into the destination clock domain. The signal passes through a chain of flip-flops clocked only by the destination clock. No gate sits in front of the first stage or between stages, so each stage sees a clean sampled value.

Beside the data path, the block watches how it is being driven and raises two sticky error flags. The first flags a source that changes again too soon after a change the destination clock has sampled. The second flags a source pulse that starts and ends between two destination edges, because the receiving domain never sees such a pulse. The monitors take no parameter about the source clock, so the same instance can be placed on any crossing without extra setup. The flags hold until the next reset. Integration tests read them to find a misused crossing at the place where the misuse happens.

Top module: `cdc_bit_sync`

## Requirements
- R1: While `dst_rst_n` is low, `dst_q`, `stab_err` and `glitch_err` are all 0. Reset acts without waiting for a clock edge.
- R2: With the default of two stages, `dst_q` after destination edge n equals the value of `src_d` sampled at edge n-1. An input that changes between two edges therefore appears at the output on the second edge after the change.
- R3: `dst_q` changes only on a destination clock edge. A change of `src_d` between edges leaves `dst_q` unchanged until the next edge.
- R4: If `src_d` is sampled at an edge with a value different from the previous sample, and another such change is sampled within the next two edges, `stab_err` becomes 1 after the edge that sees the second change.
- R5: Changes of `src_d` that are sampled three or more edges apart never set `stab_err`.
- R6: If `src_d` makes an even, nonzero number of transitions between two destination edges, so that it returns to its previously sampled value, `glitch_err` becomes 1 after the next edge.
- R7: A single transition of `src_d` between two edges never sets `glitch_err`.
- R8: Once set, `stab_err` and `glitch_err` stay 1 whatever the input does. Only reset returns them to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Asynchronous active-low reset for all state |
| src_d | input | 1 | Level from the foreign clock domain |
| dst_q | output | 1 | Synchronized level in the destination domain |
| stab_err | output | 1 | Sticky flag: input changed again too soon after a sampled change |
| glitch_err | output | 1 | Sticky flag: an input pulse fell between two destination edges |

## Verification
The hardest condition to reach is a pulse that starts and ends between two destination edges. A bench that only changes the input once per clock period never produces it. The stimulus therefore places two input transitions inside one period, clear of both edges, in directed steps and in random cycles where the level is otherwise held. Stability violations need changes one or two edges apart, while changes spaced three or more edges apart must leave the flag clear. The random phase mixes both spacings, and repeated resets let each flag be observed both rising and staying clear.

// File: rtl/cdc_sync_pkg.sv
package cdc_sync_pkg;

   // Default depth of the synchronizing register chain.
   localparam int unsigned SYNC_STAGES_DEF = 2;
   // Destination edges over which a sampled change must hold, counting the edge that saw it.
   localparam int unsigned HOLD_EDGES_DEF  = 3;
   // Width of the source-edge transition counter used by the pulse monitor.
   localparam int unsigned EDGE_CNT_W_DEF  = 3;

   // Pair of sticky usage flags.
   typedef struct packed {
      logic stab;
      logic glitch;
   } usage_flags_t;

   // Modular distance travelled by a wrapping counter between two samples.
   function automatic logic [7:0] wrap_dist(input logic [7:0] now_v,
                                            input logic [7:0] then_v,
                                            input int unsigned w);
      logic [7:0] diff;
      logic [7:0] mask;
      diff = now_v - then_v;
      mask = 8'((16'd1 << w) - 16'd1);
      return diff & mask;
   endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] stg;

   // Each stage is a plain flop; nothing combinational between stages.
   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= 1'b0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= 1'b0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/stab_mon.sv
module stab_mon #(
   parameter int unsigned HOLD_EDGES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic viol
);

   localparam int unsigned WIN_W   = (HOLD_EDGES > 2) ? $clog2(HOLD_EDGES) : 1;
   localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(HOLD_EDGES - 1);

   logic             last_smp;
   logic [WIN_W-1:0] win_left;
   logic             changed;
   logic             in_window;

   assign changed   = (d != last_smp);
   assign in_window = (win_left != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_smp <= 1'b0;
         win_left <= '0;
      end else begin
         last_smp <= d;
         if (changed)        win_left <= WIN_LOAD;
         else if (in_window) win_left <= win_left - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      viol <= 1'b0;
      else if (changed && in_window)   viol <= 1'b1;
   end

endmodule

// File: rtl/glitch_mon.sv
module glitch_mon #(
   parameter int unsigned CNT_W = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic viol
);

   import cdc_sync_pkg::*;

   logic [CNT_W-1:0] edge_cnt;
   logic [CNT_W-1:0] cnt_seen;
   logic             lvl_seen;
   logic [7:0]       moved;
   logic             returned;

   // Counts every transition of the input, clocked by the input itself.
   always_ff @(posedge d or negedge d or negedge rst_n) begin
      if (!rst_n) edge_cnt <= '0;
      else        edge_cnt <= edge_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_seen <= '0;
         lvl_seen <= 1'b0;
      end else begin
         cnt_seen <= edge_cnt;
         lvl_seen <= d;
      end
   end

   assign moved    = wrap_dist(8'(edge_cnt), 8'(cnt_seen), CNT_W);
   assign returned = (d == lvl_seen) && (moved != 8'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        viol <= 1'b0;
      else if (returned) viol <= 1'b1;
   end

endmodule

// File: rtl/cdc_bit_sync.sv
module cdc_bit_sync #(
   parameter int unsigned STAGES     = cdc_sync_pkg::SYNC_STAGES_DEF,
   parameter int unsigned HOLD_EDGES = cdc_sync_pkg::HOLD_EDGES_DEF,
   parameter int unsigned CNT_W      = cdc_sync_pkg::EDGE_CNT_W_DEF,
   parameter bit          MONITOR_EN = 1'b1
) (
   input  logic dst_clk,
   input  logic dst_rst_n,
   input  logic src_d,
   output logic dst_q,
   output logic stab_err,
   output logic glitch_err
);

   import cdc_sync_pkg::*;

   if (STAGES < 2) begin : g_bad_stages
      $error("cdc_bit_sync: STAGES must be at least 2");
   end
   if (HOLD_EDGES < 2) begin : g_bad_hold
      $error("cdc_bit_sync: HOLD_EDGES must be at least 2");
   end
   if (CNT_W < 2 || CNT_W > 8) begin : g_bad_cnt
      $error("cdc_bit_sync: CNT_W must lie in 2..8");
   end

   usage_flags_t flags;

   sync_chain #(.STAGES(STAGES)) u_chain (
      .clk   (dst_clk),
      .rst_n (dst_rst_n),
      .d     (src_d),
      .q     (dst_q)
   );

   if (MONITOR_EN) begin : g_mon
      stab_mon #(.HOLD_EDGES(HOLD_EDGES)) u_stab (
         .clk   (dst_clk),
         .rst_n (dst_rst_n),
         .d     (src_d),
         .viol  (flags.stab)
      );
      glitch_mon #(.CNT_W(CNT_W)) u_glitch (
         .clk   (dst_clk),
         .rst_n (dst_rst_n),
         .d     (src_d),
         .viol  (flags.glitch)
      );
   end else begin : g_no_mon
      assign flags = '0;
   end

   assign stab_err   = flags.stab;
   assign glitch_err = flags.glitch;

endmodule

module cdc_bit_sync_chk #(
   parameter int unsigned STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic src_d,
   input logic dst_q,
   input logic stab_err,
   input logic glitch_err
);

   int unsigned cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cyc <= 0;
      else if (cyc < 1000) cyc <= cyc + 1;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_clear_R1: assert (dst_q == 1'b0 && stab_err == 1'b0 && glitch_err == 1'b0)
            else $error("outputs not cleared in reset");
      end
   end

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (STAGES == 2 && cyc >= 3) |-> (dst_q == $past(src_d, 2)));

   assert_stab_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 3 && src_d != $past(src_d) && $past(src_d) != $past(src_d, 2)) |=> stab_err);

   assert_glitch_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 3 && $rose(glitch_err)) |-> ($past(src_d) == $past(src_d, 2)));

   assert_stab_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stab_err |=> stab_err);

   assert_glitch_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      glitch_err |=> glitch_err);

endmodule

bind cdc_bit_sync cdc_bit_sync_chk #(.STAGES(STAGES)) u_chk (
   .clk        (dst_clk),
   .rst_n      (dst_rst_n),
   .src_d      (src_d),
   .dst_q      (dst_q),
   .stab_err   (stab_err),
   .glitch_err (glitch_err)
);

// File: tb/cdc_bit_sync_bench.sv
module cdc_bit_sync_bench;

   localparam int HOLD = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic src_d = 1'b0;
   logic dst_q, stab_err, glitch_err;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // Reference state derived from the requirements.
   logic cur, e_q1, e_q, e_stab, e_glitch, m_prev, pend_glitch;
   int   edge_i, last_chg;

   cdc_bit_sync u_cdc_bit_sync (
      .dst_clk    (clk),
      .dst_rst_n  (rst_n),
      .src_d      (src_d),
      .dst_q      (dst_q),
      .stab_err   (stab_err),
      .glitch_err (glitch_err)
   );

   always #4 clk = ~clk;

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      e_q1 = 0; e_q = 0; e_stab = 0; e_glitch = 0;
      m_prev = 0; pend_glitch = 0; last_chg = -100; edge_i = 0; cur = 0;
   endtask

   // Expected stability outcome: a sampled change closer than HOLD edges to the previous one.
   function automatic logic too_soon(input int now_e, input int prev_e);
      return (now_e - prev_e) < HOLD;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      src_d = 1'b0;
      check("R1", dst_q, 1'b0);
      check("R1", stab_err, 1'b0);
      check("R1", glitch_err, 1'b0);
      repeat (2) @(posedge clk);
      #1;
      check("R1", dst_q, 1'b0);
      check("R8", stab_err, 1'b0);
      check("R8", glitch_err, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   // One destination period: update the model at the edge, check, then drive.
   task automatic step(input logic val, input logic glitch, input string stag, input string gtag);
      logic q_hold;
      logic do_g;
      @(posedge clk);
      e_q  = e_q1;
      e_q1 = cur;
      if (cur != m_prev) begin
         if (too_soon(edge_i, last_chg)) e_stab = 1'b1;
         last_chg = edge_i;
         m_prev   = cur;
      end
      if (pend_glitch) e_glitch = 1'b1;
      pend_glitch = 1'b0;
      edge_i++;
      #1;
      check("R2", dst_q, e_q);
      check(stag, stab_err, e_stab);
      check(gtag, glitch_err, e_glitch);
      q_hold = dst_q;
      do_g = glitch && (val == cur);
      #1;
      src_d = val;
      cur   = val;
      if (do_g) begin
         #1 src_d = ~val;
         #1 src_d = val;
         pend_glitch = 1'b1;
      end else begin
         #2;
      end
      #1;
      check("R3", dst_q, q_hold);
   endtask

   initial begin
      model_reset();
      #1 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check("R1", dst_q, 1'b0);
      check("R1", stab_err, 1'b0);
      check("R1", glitch_err, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();

      // Widely spaced changes: latency only, no flags (R5, R7).
      for (int k = 0; k < 8; k++) begin
         step(k[0] ? 1'b0 : 1'b1, 1'b0, "R5", "R7");
         repeat (3) step(cur, 1'b0, "R5", "R7");
      end

      // Change seen one edge after another change (R4), then sticky (R8).
      step(1'b1, 1'b0, "R4", "R7");
      step(1'b0, 1'b0, "R4", "R7");
      repeat (3) step(cur, 1'b0, "R4", "R7");
      repeat (6) step(cur, 1'b0, "R8", "R7");
      for (int k = 0; k < 6; k++) step(k[1], 1'b0, "R8", "R7");

      // Change two edges after another change (R4).
      do_reset();
      step(1'b1, 1'b0, "R4", "R7");
      step(1'b1, 1'b0, "R4", "R7");
      step(1'b0, 1'b0, "R4", "R7");
      repeat (3) step(cur, 1'b0, "R4", "R7");

      // Pulse hidden between edges (R6), then sticky (R8).
      do_reset();
      repeat (4) step(1'b0, 1'b0, "R5", "R6");
      step(1'b0, 1'b1, "R5", "R6");
      repeat (2) step(1'b0, 1'b0, "R5", "R6");
      repeat (4) step(1'b1, 1'b0, "R8", "R8");
      step(1'b1, 1'b1, "R8", "R6");
      repeat (4) step(cur, 1'b0, "R8", "R8");

      // Random mix with a fixed seed.
      void'($urandom(32'd20240607));
      for (int blk = 0; blk < 6; blk++) begin
         do_reset();
         for (int k = 0; k < 500; k++) begin
            logic nv, g;
            nv = ($urandom % 6 == 0) ? ~cur : cur;
            g  = (blk > 1) && ($urandom % 40 == 0);
            step(nv, g, "R4", "R6");
         end
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule